// File: doc/BRIEF.md
# Program Counter and Next-Address Unit

This unit keeps the program counter of a single-cycle processor. Each cycle it presents the current instruction address to an external instruction memory that reads combinationally, passes the returned 32-bit word on unchanged, and offers the incremented address to the rest of the datapath. On the next rising clock edge it loads either the sequential address or a relative branch target.

Control supplies a single flag that says whether the current instruction is a conditional branch. The ALU supplies its zero result. The unit combines the two internally to decide whether the branch is taken. A taken branch adds the sign-extended 16-bit immediate, scaled by four, to the incremented address.

The memory is addressed in words, so the two low address bits never leave the unit. All address arithmetic wraps modulo 2^32.

Top module: `fetch_npc`

## Requirements
- R1: With `rst` high at a rising edge, the PC becomes 0x00000000 at that edge. Afterwards `imem_addr` reads 0 and `pc_plus4` reads 4. This holds even when reset is applied in the middle of a run.
- R2: `instr` always equals `imem_data`, which the memory returns for the current `imem_addr`.
- R3: `pc_plus4` equals the current PC plus 4.
- R4: When `is_branch` is 0, the PC advances by 4 at the next edge, whatever the value of `alu_zero`.
- R5: When `is_branch` is 1 and `alu_zero` is 0, the PC advances by 4 at the next edge.
- R6: When `is_branch` is 1 and `alu_zero` is 1, the next PC is PC + 4 + (sign-extended `imm16` shifted left by 2).
- R7: A negative `imm16` (bit 15 set) gives a backward branch target below PC + 4.
- R8: Sequential and branch address arithmetic wraps modulo 2^32. PC 0xFFFFFFFC steps to 0, and a backward branch from PC 0 with `imm16` = 0xFFFE lands on 0xFFFFFFFC.
- R9: `imem_addr` is the word address PC[31:2]. PC bits [1:0] stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| is_branch | input | 1 | Current instruction is a conditional branch |
| alu_zero | input | 1 | ALU result was zero |
| imm16 | input | 16 | Immediate field of the current instruction |
| imem_data | input | 32 | Word read from instruction memory |
| imem_addr | output | 30 | Word address to instruction memory (PC[31:2]) |
| instr | output | 32 | Fetched instruction word |
| pc_plus4 | output | 32 | Current PC plus 4 |

## Verification
A corrupted PC shows up on `imem_addr` and `pc_plus4` in the same cycle. It also changes `instr`, because the bench's memory model returns address-dependent words. A wrong select or offset therefore shows one edge after the offending instruction. A wrong sign extension appears only on backward branches. A missing carry appears only across the top of the address space. For this reason the directed tests include negative offsets and wrap-around branches.

// File: rtl/fetch_npc.sv
module fetch_npc #(
  parameter int XLEN = 32,
  parameter int IMM_W = 16,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             is_branch,
  input  logic             alu_zero,
  input  logic [IMM_W-1:0] imm16,
  input  logic [XLEN-1:0]  imem_data,
  output logic [XLEN-3:0]  imem_addr,
  output logic [XLEN-1:0]  instr,
  output logic [XLEN-1:0]  pc_plus4
);
  localparam int AW = XLEN - 2;
  localparam int EXT_W = XLEN - IMM_W - 2;

  logic [XLEN-1:0] pc, seq_pc, br_off, br_pc, next_pc;
  logic take;

  assign seq_pc  = pc + XLEN'(4);
  assign br_off  = {{EXT_W{imm16[IMM_W-1]}}, imm16, 2'b00};
  assign br_pc   = seq_pc + br_off;
  assign take    = is_branch & alu_zero;
  assign next_pc = take ? br_pc : seq_pc;

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= next_pc;
  end

  assign imem_addr = pc[XLEN-1:2];
  assign instr     = imem_data;
  assign pc_plus4  = seq_pc;

  a_r1_reset_vector: assert property (@(posedge clk)
    rst |=> imem_addr == RESET_PC[XLEN-1:2]);

  a_r4_sequential: assert property (@(posedge clk) disable iff (rst)
    !is_branch |=> imem_addr == $past(imem_addr) + AW'(1));

  a_r5_not_taken: assert property (@(posedge clk) disable iff (rst)
    (is_branch && !alu_zero) |=> imem_addr == $past(imem_addr) + AW'(1));

  // R6 and R7: target offset is signed, in words
  a_r6_taken: assert property (@(posedge clk) disable iff (rst)
    (is_branch && alu_zero) |=>
      imem_addr == $past(imem_addr) + AW'(1) + AW'($signed($past(imm16))));

  a_r9_word_aligned: assert property (@(posedge clk) disable iff (rst)
    pc_plus4[1:0] == 2'b00);
endmodule

// File: tb/fetch_npc_tb.sv
module fetch_npc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        is_branch = 1'b0;
  logic        alu_zero = 1'b0;
  logic [15:0] imm16 = '0;
  logic [31:0] imem_data;
  logic [29:0] imem_addr;
  logic [31:0] instr, pc_plus4;
  logic [31:0] exp_pc;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [29:0] a);
    return {a, 2'b01} ^ 32'hC3A5_0F96;
  endfunction

  assign imem_data = mem_word(imem_addr);

  fetch_npc u_dut (
    .clk(clk), .rst(rst), .is_branch(is_branch), .alu_zero(alu_zero),
    .imm16(imm16), .imem_data(imem_data), .imem_addr(imem_addr),
    .instr(instr), .pc_plus4(pc_plus4)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    chk({tag, " R9 imem_addr"}, {2'b00, imem_addr}, {2'b00, exp_pc[31:2]});
    chk({tag, " R3 pc_plus4"}, pc_plus4, exp_pc + 32'd4);
    chk({tag, " R2 instr"}, instr, mem_word(exp_pc[31:2]));
  endtask

  task automatic step(input string tag, input logic br, input logic z, input logic [15:0] imm);
    is_branch = br;
    alu_zero  = z;
    imm16     = imm;
    if (br && z) exp_pc = exp_pc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
    else         exp_pc = exp_pc + 32'd4;
    @(negedge clk); #1;
    check_state(tag);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk); #1;
    exp_pc = 32'h0;
    check_state("R1 reset");
    rst = 1'b0;
  endtask

  task automatic t_sequential();
    step("R4 seq zero0", 1'b0, 1'b0, 16'h0010);
    step("R4 seq zero1", 1'b0, 1'b1, 16'h0010);
    step("R4 seq zero1 neg", 1'b0, 1'b1, 16'h8000);
  endtask

  task automatic t_not_taken();
    step("R5 not taken", 1'b1, 1'b0, 16'h0040);
    step("R5 not taken neg", 1'b1, 1'b0, 16'hFFF0);
  endtask

  task automatic t_forward();
    step("R6 forward", 1'b1, 1'b1, 16'h0020);
    step("R6 forward max", 1'b1, 1'b1, 16'h7FFF);
    step("R6 zero offset", 1'b1, 1'b1, 16'h0000);
  endtask

  task automatic t_backward();
    step("R7 backward", 1'b1, 1'b1, 16'hFFFD);
    step("R7 backward min", 1'b1, 1'b1, 16'h8000);
  endtask

  task automatic t_wrap();
    t_reset();
    step("R8 wrap below zero", 1'b1, 1'b1, 16'hFFFE);
    chk("R8 pc top", {imem_addr, 2'b00}, 32'hFFFF_FFFC);
    step("R8 wrap to zero", 1'b0, 1'b0, 16'h0000);
    chk("R8 pc zero", {imem_addr, 2'b00}, 32'h0000_0000);
  endtask

  task automatic t_midrun_reset();
    step("R6 pre reset", 1'b1, 1'b1, 16'h0100);
    rst = 1'b1;
    is_branch = 1'b1; alu_zero = 1'b1; imm16 = 16'h0400;
    @(negedge clk); #1;
    exp_pc = 32'h0;
    check_state("R1 midrun reset");
    rst = 1'b0;
    step("R4 after reset", 1'b0, 1'b0, 16'h0000);
  endtask

  initial begin
    exp_pc = 32'h0;
    t_reset();
    t_sequential();
    t_not_taken();
    t_forward();
    t_backward();
    t_wrap();
    t_midrun_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule